// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

The block collects eight interrupt inputs and turns them into prioritized vectored requests for a processor. Software reaches it through one write port and one read port with a single address bit: address 0 carries command bytes, address 1 carries data and the mask. A command byte of 0x11 starts a three-step setup sequence on address 1. The steps give the vector base, the cascade word and the mode word. After setup, address 1 writes load the mask.

Each input is edge-detected into a request register. A fixed-priority resolver compares the pending unmasked requests with the in-service register and drives `int_req`. A one-cycle `int_ack` pulse moves the winning request into service and returns the vector on the next cycle. Service ends with a specific end-of-interrupt command, or automatically when the mode word asks for it.

The cascade word is stored and shown on `casc_cfg`. A master uses it as a one-hot map of the inputs that have a slave attached. A slave uses it as the binary number of the master input it drives. Two instances can therefore form a sixteen-input pair, with the slave given a vector base eight above the master. Finishing a slave interrupt then needs one end-of-interrupt to the slave for its own level and one to the master for the cascade input.

The setup machine has four states, and each state names what the next address-1 write is for:
- CFG_RUN: normal operation. An address-1 write loads the mask.
- CFG_BASE: the next address-1 write is the vector base.
- CFG_CASC: the next address-1 write is the cascade word.
- CFG_MODE: the next address-1 write is the mode word.

Its transitions are:
- START: a 0x11 command, taken from any state, enters CFG_BASE.
- BASE_TAKEN: CFG_BASE moves to CFG_CASC.
- CASC_TAKEN: CFG_CASC moves to CFG_MODE.
- MODE_TAKEN: CFG_MODE moves to CFG_RUN.

Top module: `prog_irq_ctrl`

## Requirements
- R1: A command write of 0x11 enters CFG_BASE. The next three data writes are taken in turn as the vector base, the cascade word and the mode word, and none of them changes the mask. The cascade word then appears on `casc_cfg`.
- R2: After reset, and in the cycle after a 0x11 command, the following hold:
  - the mask, request and in-service registers read zero;
  - auto end-of-interrupt is off;
  - command-address reads return the request register.
- R3: In CFG_RUN, a data write loads the mask and a data read returns it. A mask bit of 1 keeps that input from raising `int_req`, but its request bit still latches.
- R4: A rising edge on `irq_in[i]` sets request bit i. The bit stays set while the input stays high or falls, until an acknowledge takes it. Only a new rising edge sets it again.
- R5: Priority is fixed, with input 0 highest. `int_req` is 1 exactly when some unmasked request is pending whose level is higher than every set in-service bit.
- R6: An `int_ack` pulse while `int_req` is 1 does three things:
  - it raises `vec_valid` for one cycle on the next cycle;
  - `vec_out` then shows the vector base plus the winning level;
  - the winning request bit is cleared and its in-service bit is set.
- R7: An `int_ack` pulse while `int_req` is 0 returns the vector base plus 7, and leaves the request and in-service registers unchanged.
- R8: Command 0x0B selects the in-service register for command-address reads, and command 0x0A selects the request register. Any other command outside 0x11 and 0x60 to 0x67 has no effect.
- R9: Command 0x60 plus a level L in bits 2:0 clears in-service bit L only.
- R10: When mode word bit 1 is 1, auto end-of-interrupt is on and an acknowledge sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_sel | input | 1 | Address: 0 selects command, 1 selects data and mask |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte: the mask when bus_sel is 1, otherwise the selected request or in-service register |
| irq_in | input | 8 | Interrupt inputs, edge-detected |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge pulse |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec_out | output | 8 | Returned vector |
| casc_cfg | output | 8 | Stored cascade word |

## Verification
A request or in-service bit that is wrongly set or lost shows at the ports in one of three ways. `int_req` may change within a cycle of the fault. The vector returned on the next acknowledge may be wrong. A command-address read after a 0x0A or 0x0B command may return the wrong value. A setup machine that is out of step shows on the very next data read: the mask comes back altered, or `casc_cfg` does not match.

The bench is built around a scoreboard. Each acknowledge pushes its expected vector into a queue. A monitor compares every `vec_valid` cycle against that queue, so any vector that is wrong, early, or missing is reported.

// File: rtl/pic_pkg.sv
package pic_pkg;
    typedef enum logic [1:0] {
        CFG_RUN  = 2'd0,
        CFG_BASE = 2'd1,
        CFG_CASC = 2'd2,
        CFG_MODE = 2'd3
    } cfg_state_t;

    typedef enum logic {
        RSEL_REQ = 1'b0,
        RSEL_SVC = 1'b1
    } rsel_t;

    localparam logic [7:0] CMD_INIT     = 8'h11;
    localparam logic [7:0] CMD_RD_REQ   = 8'h0A;
    localparam logic [7:0] CMD_RD_SVC   = 8'h0B;
    localparam logic [4:0] CMD_EOI_HI   = 5'b01100;
    localparam int         MODE_AEOI_BIT = 1;
endpackage

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [LW-1:0] lvl
);
    // Lowest index wins: scan from the top down so index 0 is assigned last.
    always_comb begin
        any = |vec;
        lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) lvl = LW'(i);
        end
    end
endmodule

// File: rtl/pic_cfg_ctrl.sv
module pic_cfg_ctrl
    import pic_pkg::*;
#(
    parameter int DW = 8,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] vbase,
    output logic [DW-1:0] casc,
    output logic          aeoi,
    output rsel_t         rsel,
    output logic          init_stb,
    output logic          eoi_stb,
    output logic [LW-1:0] eoi_lvl
);
    cfg_state_t state_q, state_d;
    logic cmd_wr, dat_wr;

    assign cmd_wr = we && !sel;
    assign dat_wr = we && sel;

    // Command decode (init may arrive in any state)
    always_comb begin
        init_stb = cmd_wr && (wdata == CMD_INIT);
        eoi_stb  = cmd_wr && (state_q == CFG_RUN) && (wdata[7:3] == CMD_EOI_HI);
        eoi_lvl  = wdata[LW-1:0];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (init_stb) begin
            state_d = CFG_BASE;
        end else if (dat_wr) begin
            unique case (state_q)
                CFG_RUN:  state_d = CFG_RUN;
                CFG_BASE: state_d = CFG_CASC;
                CFG_CASC: state_d = CFG_MODE;
                CFG_MODE: state_d = CFG_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_RUN;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            vbase <= '0;
            casc  <= '0;
            aeoi  <= 1'b0;
            rsel  <= RSEL_REQ;
        end else if (init_stb) begin
            mask  <= '0;
            aeoi  <= 1'b0;
            rsel  <= RSEL_REQ;
        end else if (dat_wr) begin
            unique case (state_q)
                CFG_RUN:  mask  <= wdata;
                CFG_BASE: vbase <= wdata;
                CFG_CASC: casc  <= wdata;
                CFG_MODE: aeoi  <= wdata[MODE_AEOI_BIT];
            endcase
        end else if (cmd_wr && state_q == CFG_RUN) begin
            if (wdata == CMD_RD_SVC)      rsel <= RSEL_SVC;
            else if (wdata == CMD_RD_REQ) rsel <= RSEL_REQ;
        end
    end

    a_r1_mode_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_MODE && dat_wr && !init_stb) |=> (state_q == CFG_RUN));
    a_r1_no_mask_in_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CFG_RUN && !init_stb) |=> $stable(mask));
    a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> (mask == '0 && !aeoi && rsel == RSEL_REQ && state_q == CFG_BASE));
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic [N-1:0]  mask,
    input  logic          init_stb,
    input  logic          ack,
    input  logic          aeoi,
    input  logic          eoi_stb,
    input  logic [LW-1:0] eoi_lvl,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic          int_req,
    output logic          vec_valid,
    output logic [LW-1:0] vec_lvl
);
    logic [N-1:0]  prev_q, rise, pend, grant_vec, eoi_vec;
    logic          pend_any, svc_any, grant;
    logic [LW-1:0] pend_lvl, svc_lvl;

    pic_prio_enc #(.N(N)) u_pend_enc (.vec(pend), .any(pend_any), .lvl(pend_lvl));
    pic_prio_enc #(.N(N)) u_svc_enc  (.vec(isr),  .any(svc_any),  .lvl(svc_lvl));

    always_comb begin
        rise    = irq_in & ~prev_q;
        pend    = irr & ~mask;
        int_req = pend_any && (!svc_any || pend_lvl < svc_lvl);
        grant   = ack && int_req;
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            assign grant_vec[g] = grant && (pend_lvl == LW'(g));
            assign eoi_vec[g]   = eoi_stb && (eoi_lvl == LW'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            irr       <= '0;
            isr       <= '0;
            vec_valid <= 1'b0;
            vec_lvl   <= '0;
        end else begin
            prev_q    <= irq_in;
            vec_valid <= ack;
            if (ack) vec_lvl <= grant ? pend_lvl : LW'(N - 1);
            if (init_stb) begin
                irr <= '0;
                isr <= '0;
            end else begin
                irr <= (irr & ~grant_vec) | rise;
                isr <= (isr & ~eoi_vec) | (aeoi ? '0 : grant_vec);
            end
        end
    end

    a_r6_ack_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !init_stb) |=> ((irr & $past(irr)) == $past(irr)));
    a_r5_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (|(irr & ~mask)));
    a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_stb && !ack) |=> !isr[$past(eoi_lvl)]);
    a_r10_aeoi_no_svc: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !init_stb) |=> ((isr & ~$past(isr)) == '0));
    a_r7_spurious_still: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_req && !eoi_stb && !init_stb) |=> $stable(isr));
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
    import pic_pkg::*;
#(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic         bus_sel,
    input  logic [N-1:0] bus_wdata,
    output logic [N-1:0] bus_rdata,
    input  logic [N-1:0] irq_in,
    output logic         int_req,
    input  logic         int_ack,
    output logic         vec_valid,
    output logic [N-1:0] vec_out,
    output logic [N-1:0] casc_cfg
);
    logic [N-1:0]  mask, vbase, irr, isr;
    logic          aeoi, init_stb, eoi_stb;
    logic [LW-1:0] eoi_lvl, vec_lvl;
    rsel_t         rsel;

    pic_cfg_ctrl #(.DW(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .sel(bus_sel), .wdata(bus_wdata),
        .mask(mask), .vbase(vbase), .casc(casc_cfg), .aeoi(aeoi), .rsel(rsel),
        .init_stb(init_stb), .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl)
    );

    pic_req_bank #(.N(N)) u_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
        .init_stb(init_stb), .ack(int_ack), .aeoi(aeoi),
        .eoi_stb(eoi_stb), .eoi_lvl(eoi_lvl),
        .irr(irr), .isr(isr), .int_req(int_req),
        .vec_valid(vec_valid), .vec_lvl(vec_lvl)
    );

    always_comb begin
        vec_out   = vbase + {{(N - LW){1'b0}}, vec_lvl};
        bus_rdata = bus_sel ? mask : ((rsel == RSEL_SVC) ? isr : irr);
    end
endmodule

// File: tb/prog_irq_ctrl_tb.sv
module prog_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0, bus_sel = 1'b0, int_ack = 1'b0;
    logic [7:0] bus_wdata = '0, irq_in = '0;
    logic [7:0] bus_rdata, vec_out, casc_cfg;
    logic       int_req, vec_valid;
    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    prog_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_req(int_req), .int_ack(int_ack), .vec_valid(vec_valid),
        .vec_out(vec_out), .casc_cfg(casc_cfg)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Monitor: every vec_valid cycle is compared against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) check("R6 unexpected vector", vec_out, 8'hxx);
            else check("R6 vector", vec_out, exp_q.pop_front());
        end
    end

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(bit sel, output logic [7:0] v);
        @(negedge clk);
        bus_sel = sel;
        #1 v = bus_rdata;
    endtask

    task automatic drive_irq(logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ack(logic [7:0] expv);
        @(negedge clk);
        int_ack = 1'b1;
        exp_q.push_back(expv);
        @(negedge clk);
        int_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        rd(1'b1, v); check("R2 reset mask", v, 8'h00);
        rd(1'b0, v); check("R2 reset request reg", v, 8'h00);
        check("R2 reset int_req", {7'd0, int_req}, 8'h00);
        // R1 setup sequence
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
        check("R1 cascade word", casc_cfg, 8'h04);
        rd(1'b1, v); check("R1 mask untouched by setup", v, 8'h00);
        // R3 mask
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R3 mask readback", v, 8'hFF);
        drive_irq(8'h08);
        check("R3 masked int_req", {7'd0, int_req}, 8'h00);
        rd(1'b0, v); check("R3 masked request latched", v, 8'h08);
        wr(1'b1, 8'h00);
        check("R5 unmasked int_req", {7'd0, int_req}, 8'h01);
        ack(8'h23);
        // R8 readback select, R4 no relatch while high
        wr(1'b0, 8'h0B); rd(1'b0, v); check("R8 in-service select", v, 8'h08);
        wr(1'b0, 8'h33); rd(1'b0, v); check("R8 unknown cmd ignored", v, 8'h08);
        wr(1'b0, 8'h0A); rd(1'b0, v); check("R4 request cleared, no new edge", v, 8'h00);
        wr(1'b0, 8'h0B);
        // R5 priority vs in-service
        drive_irq(8'h28);
        check("R5 lower level blocked", {7'd0, int_req}, 8'h00);
        drive_irq(8'h2A);
        check("R5 higher level preempts", {7'd0, int_req}, 8'h01);
        ack(8'h21);
        rd(1'b0, v); check("R6 in-service nested", v, 8'h0A);
        wr(1'b0, 8'h61);
        rd(1'b0, v); check("R9 specific EOI level 1 only", v, 8'h08);
        check("R5 still blocked by level 3", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h63);
        check("R9 EOI 3 releases level 5", {7'd0, int_req}, 8'h01);
        ack(8'h25);
        wr(1'b0, 8'h65);
        // R4 simultaneous edges, priority order
        drive_irq(8'h00);
        drive_irq(8'h44);
        ack(8'h22);
        wr(1'b0, 8'h62);
        ack(8'h26);
        wr(1'b0, 8'h66);
        rd(1'b0, v); check("R9 all serviced", v, 8'h00);
        // R7 spurious acknowledge
        ack(8'h27);
        rd(1'b0, v); check("R7 in-service unchanged", v, 8'h00);
        check("R7 int_req low", {7'd0, int_req}, 8'h00);
        // R2 reinit clears, R10 auto EOI
        drive_irq(8'h00);
        wr(1'b1, 8'h5A);
        drive_irq(8'h10);
        wr(1'b0, 8'h11);
        rd(1'b1, v); check("R2 reinit mask cleared", v, 8'h00);
        rd(1'b0, v); check("R2 reinit request cleared", v, 8'h00);
        wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h02);
        check("R1 slave cascade id", casc_cfg, 8'h02);
        drive_irq(8'h11);
        ack(8'h28);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R10 auto EOI leaves no in-service", v, 8'h00);
        check("R10 int_req low after", {7'd0, int_req}, 8'h00);
        repeat (3) @(negedge clk);
        check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule